// File: doc/BRIEF.md
# Reset and Clock Start-up Sequencer

This controller keeps a system in reset after power arrives, after a supply dip, or after a warm reset request. It releases the system only when the supplies are good and the selected clock has gone through its start-up stages. All analog start-up delays are modelled as cycle counts on a free-running reference clock. The crystal-stabilisation stage is the exception: it counts tick pulses that come from the oscillator being started.

The release delay depends on the clock mode. It is built from up to three stages, run in this order: an oscillator start-up wait, a crystal-stabilisation tick count, and a wait for PLL lock. A cold start takes its clock mode from the configured setting. A warm start keeps the mode that is currently running. When the system leaves reset, a strobe tells the core to load its reset vector. After a further delay, and only if it is enabled, a clock monitor is switched on. If the PLL does not lock within a timeout, an error flag is raised and reset stays asserted. A one-hot cause register shows which kind of event started the last sequence.

Top module: `rst_clk_seq`

## Requirements
- R1: While `pwr_ok` or `bor_ok` is low, `sys_rst` is 1. Once both are high, a power-up wait of `PWRT_CYC` cycles runs, followed by one mode-selection cycle, before any oscillator stage begins.
- R2: Mode encoding of `clk_sel`: 0 internal RC, 1 internal RC with PLL, 2 low-speed crystal, 3 high-speed or secondary crystal, 4 crystal with PLL, 5 external clock, 6 external clock with PLL, 7 low-power RC. The start-up wait of `OSCD_CYC` cycles applies to every mode except 5 and 6. The tick stage applies to modes 2, 3 and 4. The lock wait applies to modes 1, 4 and 6, and ends on the first cycle in which `pll_locked` is seen. For a cold start, counting the edge that sees the supplies good as edge 1, `sys_rst` falls after edge PWRT_CYC+2, plus OSCD_CYC if the start-up wait applies, plus OST_TICKS if the tick stage applies, plus 1 for an immediate lock.
- R3: The crystal-stabilisation stage advances only on cycles in which `osc_tick` is 1. It leaves after `OST_TICKS` such cycles, and it waits indefinitely while no ticks arrive.
- R4: `clk_sel` takes `cfg_mode` as sampled on the edge that ends the supply wait, and it reloads from `cfg_mode` on any cold event. A warm reset loads `act_mode`. While the system is out of reset, `clk_sel` does not change.
- R5: A `warm_req` seen outside the supply wait and the power-up wait restarts at the mode-selection cycle. Counting the request edge as edge 1, `sys_rst` then falls after edge 2 plus the stage terms of R2. A warm request seen during the supply wait or the power-up wait has no effect on timing or on the cause register.
- R6: A low `pwr_ok` or `bor_ok` at any time, including while running, returns the block to the full cold sequence and sets `sys_rst` on the next edge.
- R7: `vec_load` is 1 for exactly the first cycle in which `sys_rst` is 0.
- R8: When `mon_cfg` is 1, `mon_en` rises `MON_CYC` cycles after release and stays high while the system is running. When `mon_cfg` is 0, `mon_en` stays 0.
- R9: If `pll_locked` stays low for `LOCK_TMO` cycles in the lock wait, `lock_err` is set and `sys_rst` stays 1 until the next cold or accepted warm event. For a cold start of mode 1, counting as in R2, `lock_err` rises after edge PWRT_CYC+2+OSCD_CYC+LOCK_TMO.
- R10: `cause` is one-hot: bit 0 power-on (`pwr_ok` low), bit 1 brown-out (`bor_ok` low while `pwr_ok` is high), bit 2 accepted warm reset. The most recent event overwrites the register. Power-on has priority over brown-out. `cause_clr` sets the register to 0 unless an event arrives in the same cycle, in which case the event wins. Block reset sets the register to 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pwr_ok | input | 1 | Supply above power-on threshold |
| bor_ok | input | 1 | Supply above brown-out threshold |
| warm_req | input | 1 | Warm reset request |
| cfg_mode | input | 3 | Configured clock mode for cold starts |
| act_mode | input | 3 | Clock mode currently running |
| pll_locked | input | 1 | PLL lock indication |
| osc_tick | input | 1 | One pulse per cycle of the starting oscillator |
| mon_cfg | input | 1 | Clock monitor enabled by configuration |
| cause_clr | input | 1 | Clears the cause register |
| sys_rst | output | 1 | System reset, active high |
| clk_sel | output | 3 | Chosen clock mode |
| vec_load | output | 1 | Reset-vector load strobe |
| mon_en | output | 1 | Clock monitor enable |
| lock_err | output | 1 | PLL lock timeout flag |
| cause | output | 3 | One-hot reset cause |

## Verification
The assertions check these rules on every cycle:
- A supply fault forces reset on the next edge.
- The vector strobe is a single pulse that coincides with release.
- The monitor enable and the lock-error flag never appear while the state contradicts them.
- The clock mode does not move while the system is running.
- The tick stage does not advance without ticks.
- The cause register is never more than one-hot.

Only the bench's scenarios can show:
- The exact release latency for each mode, for both cold and warm starts, compared against the stage sum.
- Cold versus warm source selection.
- Warm requests being ignored during the power-up wait.
- The lock timeout and recovery from it.
- Cause priority and clear ordering.

// File: rtl/su_pkg.sv
package su_pkg;
  typedef enum logic [2:0] {
    M_RC = 3'd0, M_RC_PLL = 3'd1, M_XT_LO = 3'd2, M_XT_HI = 3'd3,
    M_XT_PLL = 3'd4, M_EXT = 3'd5, M_EXT_PLL = 3'd6, M_RC_LOW = 3'd7
  } osc_mode_e;

  typedef enum logic [2:0] {
    S_HOLD, S_PWRT, S_SEL, S_OSCD, S_OST, S_LOCK, S_RUN, S_ERR
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/su_mode_decode.sv
module su_mode_decode
  import su_pkg::*;
(
  input  logic [2:0] mode,
  output logic       use_oscd,
  output logic       use_ost,
  output logic       use_pll
);
  always_comb begin
    use_oscd = 1'b1;
    use_ost  = 1'b0;
    use_pll  = 1'b0;
    case (osc_mode_e'(mode))
      M_RC, M_RC_LOW: ;
      M_RC_PLL:       use_pll = 1'b1;
      M_XT_LO, M_XT_HI: use_ost = 1'b1;
      M_XT_PLL: begin
        use_ost = 1'b1;
        use_pll = 1'b1;
      end
      M_EXT:          use_oscd = 1'b0;
      M_EXT_PLL: begin
        use_oscd = 1'b0;
        use_pll  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/su_delay_cnt.sv
module su_delay_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic         cnt_ld;

  always_comb begin
    cnt_ld = clr | en;
    cnt_d  = clr ? '0 : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ld) cnt <= cnt_d;
  end
endmodule

// File: rtl/su_cause_reg.sv
module su_cause_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_por,
  input  logic       set_bor,
  input  logic       set_warm,
  input  logic       clr,
  output logic [2:0] cause
);
  logic [2:0] cause_d;
  logic       cause_ld;

  always_comb begin
    cause_ld = set_por | set_bor | set_warm | clr;
    if (set_por)       cause_d = 3'b001;
    else if (set_bor)  cause_d = 3'b010;
    else if (set_warm) cause_d = 3'b100;
    else               cause_d = 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause <= 3'b001;
    else if (cause_ld) cause <= cause_d;
  end

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause));  // R10
  AST_CAUSE_POR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_por |=> (cause == 3'b001));  // R10
endmodule

// File: rtl/rst_clk_seq.sv
module rst_clk_seq
  import su_pkg::*;
#(
  parameter int PWRT_CYC  = 1000,
  parameter int OSCD_CYC  = 64,
  parameter int OST_TICKS = 1024,
  parameter int LOCK_TMO  = 20000,
  parameter int MON_CYC   = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       bor_ok,
  input  logic       warm_req,
  input  logic [2:0] cfg_mode,
  input  logic [2:0] act_mode,
  input  logic       pll_locked,
  input  logic       osc_tick,
  input  logic       mon_cfg,
  input  logic       cause_clr,
  output logic       sys_rst,
  output logic [2:0] clk_sel,
  output logic       vec_load,
  output logic       mon_en,
  output logic       lock_err,
  output logic [2:0] cause
);
  localparam int unsigned MAXV = max2(max2(max2(PWRT_CYC, OSCD_CYC), max2(OST_TICKS, LOCK_TMO)), MON_CYC);
  localparam int CW = $clog2(MAXV + 1);
  localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_CYC - 1);
  localparam logic [CW-1:0] OSCD_LAST = CW'(OSCD_CYC - 1);
  localparam logic [CW-1:0] OST_LAST  = CW'(OST_TICKS - 1);
  localparam logic [CW-1:0] TMO_LAST  = CW'(LOCK_TMO - 1);
  localparam logic [CW-1:0] MON_FULL  = CW'(MON_CYC);

  seq_state_e    state, state_nxt;
  logic [CW-1:0] cnt;
  logic          cnt_clr, cnt_en;
  logic          cold, warm_acc;
  logic          use_oscd, use_ost, use_pll;
  logic [2:0]    sel_d;
  logic          sel_ld;

  su_mode_decode u_dec (
    .mode(clk_sel), .use_oscd(use_oscd), .use_ost(use_ost), .use_pll(use_pll)
  );

  su_delay_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .en(cnt_en), .cnt(cnt)
  );

  su_cause_reg u_cause (
    .clk(clk), .rst_n(rst_n),
    .set_por(!pwr_ok), .set_bor(pwr_ok && !bor_ok), .set_warm(warm_acc),
    .clr(cause_clr), .cause(cause)
  );

  // Cold events override everything; warm is accepted only after the power-up wait
  always_comb begin
    cold     = !pwr_ok || !bor_ok;
    warm_acc = warm_req && !cold && (state != S_HOLD) && (state != S_PWRT);
  end

  always_comb begin
    state_nxt = state;
    if (cold) begin
      state_nxt = S_HOLD;
    end else if (warm_acc) begin
      state_nxt = S_SEL;
    end else begin
      case (state)
        S_HOLD: state_nxt = S_PWRT;
        S_PWRT: if (cnt == PWRT_LAST) state_nxt = S_SEL;
        S_SEL:  state_nxt = use_oscd ? S_OSCD : (use_pll ? S_LOCK : S_RUN);
        S_OSCD: if (cnt == OSCD_LAST)
                  state_nxt = use_ost ? S_OST : (use_pll ? S_LOCK : S_RUN);
        S_OST:  if (osc_tick && cnt == OST_LAST)
                  state_nxt = use_pll ? S_LOCK : S_RUN;
        S_LOCK: if (pll_locked)           state_nxt = S_RUN;
                else if (cnt == TMO_LAST) state_nxt = S_ERR;
        default: ;
      endcase
    end
  end

  // Counter: cleared on every stage change, advanced per stage rule
  always_comb begin
    cnt_clr = (state_nxt != state);
    case (state)
      S_PWRT, S_OSCD, S_LOCK: cnt_en = 1'b1;
      S_OST:                  cnt_en = osc_tick;
      S_RUN:                  cnt_en = (cnt != MON_FULL);
      default:                cnt_en = 1'b0;
    endcase
  end

  // Clock source: configuration on cold paths, running mode on warm
  always_comb begin
    sel_ld = cold || (state == S_HOLD) || warm_acc;
    sel_d  = (cold || state == S_HOLD) ? cfg_mode : act_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_HOLD;
    else        state <= state_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      clk_sel <= 3'd0;
    else if (sel_ld) clk_sel <= sel_d;
  end

  always_comb begin
    sys_rst  = (state != S_RUN);
    vec_load = (state == S_RUN) && (cnt == '0);
    mon_en   = (state == S_RUN) && mon_cfg && (cnt == MON_FULL);
    lock_err = (state == S_ERR);
  end

  AST_COLD_FORCES_RST: assert property (@(posedge clk) disable iff (!rst_n)
    cold |=> sys_rst);  // R6
  AST_VEC_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> vec_load);  // R7
  AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |=> !vec_load);  // R7
  AST_MON_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    mon_en |-> (!sys_rst && mon_cfg));  // R8
  AST_ERR_HOLDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> sys_rst);  // R9
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && $past(!sys_rst)) |-> $stable(clk_sel));  // R4
  AST_OST_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OST && !osc_tick && !cold && !warm_acc) |=> (state == S_OST && $stable(cnt)));  // R3
endmodule

// File: tb/tb_rst_clk_seq.sv
`timescale 1ns/1ps
module tb_rst_clk_seq;
  localparam int P = 3, D = 4, T = 5, TMO = 6, M = 4;

  logic clk = 1'b0;
  logic rst_n, pwr_ok, bor_ok, warm_req, pll_locked, osc_tick, mon_cfg, cause_clr;
  logic [2:0] cfg_mode, act_mode;
  logic sys_rst, vec_load, mon_en, lock_err;
  logic [2:0] clk_sel, cause;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rst_clk_seq #(.PWRT_CYC(P), .OSCD_CYC(D), .OST_TICKS(T), .LOCK_TMO(TMO), .MON_CYC(M)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .bor_ok(bor_ok), .warm_req(warm_req),
    .cfg_mode(cfg_mode), .act_mode(act_mode), .pll_locked(pll_locked), .osc_tick(osc_tick),
    .mon_cfg(mon_cfg), .cause_clr(cause_clr), .sys_rst(sys_rst), .clk_sel(clk_sel),
    .vec_load(vec_load), .mon_en(mon_en), .lock_err(lock_err), .cause(cause)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stage_sum(input int m);
    int s = 0;
    if (m != 5 && m != 6) s += D;
    if (m >= 2 && m <= 4) s += T;
    if (m == 1 || m == 4 || m == 6) s += 1;
    return s;
  endfunction

  task automatic measure(input int warm_at, output int n);
    n = 0;
    for (int i = 0; i < 500; i++) begin
      @(posedge clk); #1;
      n++;
      warm_req = (n == warm_at);
      if (!sys_rst) break;
    end
  endtask

  task automatic cold_start(input int m);
    @(negedge clk);
    pwr_ok = 1'b0;
    cfg_mode = 3'(m);
    repeat (2) @(negedge clk);
    pwr_ok = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, k;
    bit seen;
    rst_n = 0; pwr_ok = 1; bor_ok = 1; warm_req = 0; pll_locked = 1; osc_tick = 1;
    mon_cfg = 1; cause_clr = 0; cfg_mode = 0; act_mode = 0;
    repeat (3) @(posedge clk); #1;
    chk(sys_rst == 1'b1, "R1 reset sys_rst", int'(sys_rst), 1);
    chk(cause == 3'b001, "R10 reset cause", int'(cause), 1);
    chk(vec_load == 1'b0 && mon_en == 1'b0, "R7 reset strobes", int'(vec_load), 0);
    chk(lock_err == 1'b0, "R9 reset lock_err", int'(lock_err), 0);
    @(negedge clk); rst_n = 1;

    // Sweep all modes: cold start from configuration, then warm start from running mode
    for (int m = 0; m < 8; m++) begin
      int a;
      act_mode = 3'(7 - m);
      cold_start(m);
      measure(-1, n);
      chk(n == P + 2 + stage_sum(m), "R2 cold latency", n, P + 2 + stage_sum(m));
      chk(clk_sel == 3'(m), "R4 cold source", int'(clk_sel), m);
      chk(vec_load == 1'b1, "R7 strobe at release", int'(vec_load), 1);
      chk(cause == 3'b001, "R10 power-on cause", int'(cause), 1);
      k = 0;
      for (int i = 0; i < 50; i++) begin
        @(posedge clk); #1;
        k++;
        if (k == 1) chk(vec_load == 1'b0, "R7 strobe one cycle", int'(vec_load), 0);
        if (mon_en) break;
      end
      chk(k == M, "R8 monitor delay", k, M);
      a = (m + 3) % 8;
      @(negedge clk);
      act_mode = 3'(a);
      warm_req = 1'b1;
      measure(-1, n);
      chk(n == 2 + stage_sum(a), "R5 warm latency", n, 2 + stage_sum(a));
      chk(clk_sel == 3'(a), "R4 warm source", int'(clk_sel), a);
      chk(cause == 3'b100, "R10 warm cause", int'(cause), 4);
    end

    // R5: warm request during the power-up wait is ignored
    cold_start(0);
    measure(1, n);
    chk(n == P + 2 + D, "R5 warm ignored in power-up", n, P + 2 + D);
    chk(cause == 3'b001, "R5 cause unchanged", int'(cause), 1);

    // R10: clear
    @(negedge clk); cause_clr = 1'b1;
    @(posedge clk); #1;
    chk(cause == 3'b000, "R10 clear", int'(cause), 0);
    chk(sys_rst == 1'b0, "R10 clear no reset", int'(sys_rst), 0);
    cause_clr = 1'b0;

    // R6: brown-out while running
    @(negedge clk); bor_ok = 1'b0; cfg_mode = 3'd6;
    @(posedge clk); #1;
    chk(sys_rst == 1'b1, "R6 brown-out forces reset", int'(sys_rst), 1);
    chk(mon_en == 1'b0, "R8 monitor off in reset", int'(mon_en), 0);
    chk(cause == 3'b010, "R10 brown-out cause", int'(cause), 2);
    chk(clk_sel == 3'd6, "R4 cold reload", int'(clk_sel), 6);
    @(negedge clk); bor_ok = 1'b1;
    measure(-1, n);
    chk(n == P + 2 + stage_sum(6), "R6 full cold sequence", n, P + 2 + stage_sum(6));

    // R10: power-on outranks brown-out
    @(negedge clk); pwr_ok = 1'b0; bor_ok = 1'b0;
    @(posedge clk); #1;
    chk(cause == 3'b001, "R10 priority", int'(cause), 1);
    @(negedge clk); pwr_ok = 1'b1; bor_ok = 1'b1;
    measure(-1, n);

    // R10: event beats clear in the same cycle
    @(negedge clk); cause_clr = 1'b1; warm_req = 1'b1; act_mode = 3'd5;
    @(posedge clk); #1;
    chk(cause == 3'b100, "R10 event over clear", int'(cause), 4);
    cause_clr = 1'b0; warm_req = 1'b0;
    measure(-1, n);

    // R8: monitor disabled
    mon_cfg = 1'b0;
    @(negedge clk); warm_req = 1'b1;
    measure(-1, n);
    seen = 1'b0;
    for (int i = 0; i < M + 6; i++) begin
      @(posedge clk); #1;
      if (mon_en) seen = 1'b1;
    end
    chk(seen == 1'b0, "R8 monitor stays off", int'(seen), 0);
    mon_cfg = 1'b1;

    // R3: tick stage waits for ticks
    osc_tick = 1'b0;
    cold_start(2);
    repeat (P + D + 30) @(posedge clk);
    #1;
    chk(sys_rst == 1'b1, "R3 no ticks no release", int'(sys_rst), 1);
    @(negedge clk); osc_tick = 1'b1;
    measure(-1, n);
    chk(n == T, "R3 tick count", n, T);

    // R9: lock timeout and recovery
    pll_locked = 1'b0;
    cold_start(1);
    k = 0;
    for (int i = 0; i < 500; i++) begin
      @(posedge clk); #1;
      k++;
      if (lock_err) break;
    end
    chk(k == P + 2 + D + TMO, "R9 timeout latency", k, P + 2 + D + TMO);
    repeat (20) @(posedge clk);
    #1;
    chk(lock_err == 1'b1 && sys_rst == 1'b1, "R9 error holds reset", int'(lock_err), 1);
    pll_locked = 1'b1;
    @(negedge clk); act_mode = 3'd1; warm_req = 1'b1;
    measure(-1, n);
    chk(n == 2 + stage_sum(1), "R9 warm recovery", n, 2 + stage_sum(1));
    chk(lock_err == 1'b0, "R9 error cleared", int'(lock_err), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule